// File: doc/BRIEF.md
# Spectral Magnitude Subtraction Unit

This unit removes an estimate of stationary noise from one frequency bin at a time. Each sample carries two unsigned magnitudes. The first, A, is the magnitude of the noisy spectrum. The second, B, is the magnitude of the noise estimate for the same bin.

The unit scales B by a programmable over-subtraction gain and takes the result away from A. It also computes a spectral floor, which is a programmable fraction of A. The output is the difference when the difference is strictly above the floor; otherwise the output is the floor. A negative difference therefore always falls back to the floor. This keeps residual "musical" noise from being cut down to silence.

The unit accepts one sample per clock and returns one result per sample, two cycles later. The two coefficients are loaded through a small register write port. The surrounding transform and the noise estimator drive and consume the bin stream.

Top module: `spectral_sub`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` is 0 and `out_mag` is 0. The gain resets to 1.0 (code 0x1000) and the floor fraction resets to 0.0 (code 0x0000).
- R2: The scaled noise is floor(B·gain / 4096). The gain is an unsigned value with 12 fraction bits. When the scaled noise exceeds 0xFFFF it saturates to 0xFFFF.
- R3: The floor is floor(A·frac / 65536). The floor fraction is an unsigned 16-bit value with 16 fraction bits.
- R4: The output magnitude is A minus the scaled noise when that signed difference is strictly greater than the floor. Otherwise the output is the floor. When the two are equal, the value is the floor. The output never exceeds A.
- R5: A sample taken with `in_valid` high at a rising edge gives `out_valid` high, with its result on `out_mag`, after the second rising edge that follows. Samples on consecutive cycles stream without gaps.
- R6: A write with `cfg_we` high loads `cfg_data` into the gain when `cfg_sel` is 0 and into the floor fraction when `cfg_sel` is 1. A sample taken at the same edge as the write still uses the old value. Samples taken at later edges use the new value.
- R7: While `out_valid` is low, `out_mag` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | Coefficient select: 0 gain, 1 floor fraction |
| cfg_data | input | 16 | Coefficient value to write |
| in_valid | input | 1 | Input sample strobe |
| in_a | input | 16 | Noisy-spectrum magnitude A |
| in_b | input | 16 | Noise-estimate magnitude B |
| out_valid | output | 1 | Result strobe |
| out_mag | output | 16 | Cleaned magnitude |

## Verification
A stream of bins runs with a gain of 2.0 and a floor fraction of 0.25. The stream holds:
- bins where the difference clearly wins, separating the subtract path from the floor path;
- bins where the difference lands just under the floor or equals it, which pins down the strict comparison;
- bins that go negative, which show that the sign bit is not lost;
- a noise value large enough to saturate the scaled term.

Directed cases cover the remaining behaviour:
- the reset coefficients;
- a fractional gain, to expose truncation against rounding;
- a coefficient write landing on the same edge as a sample;
- idle cycles, which show that the output holds its last result.

// File: rtl/ssub_pkg.sv
package ssub_pkg;
  localparam int unsigned MAG_W_DEF   = 16;
  localparam int unsigned GAIN_W_DEF  = 16;
  localparam int unsigned GAIN_FRAC   = 12;
  localparam int unsigned FRAC_W_DEF  = 16;

  typedef enum logic {
    COEF_GAIN  = 1'b0,
    COEF_FLOOR = 1'b1
  } coef_sel_e;
endpackage

// File: rtl/ssub_coef_regs.sv
module ssub_coef_regs #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned FRAC_W    = 16,
  parameter logic [GAIN_W-1:0] GAIN_RST = 16'h1000,
  parameter logic [FRAC_W-1:0] FRAC_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [GAIN_W-1:0] gain_q,
  output logic [FRAC_W-1:0] frac_q
);
  import ssub_pkg::*;

  logic hit_gain;
  logic hit_frac;

  assign hit_gain = wr_en && (coef_sel_e'(wr_sel) == COEF_GAIN);
  assign hit_frac = wr_en && (coef_sel_e'(wr_sel) == COEF_FLOOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= GAIN_RST;
      frac_q <= FRAC_RST;
    end else begin
      if (hit_gain) gain_q <= wr_data[GAIN_W-1:0];
      if (hit_frac) frac_q <= wr_data[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/ssub_scale_stage.sv
module ssub_scale_stage #(
  parameter int unsigned MAG_W     = 16,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 12,
  parameter int unsigned FRAC_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MAG_W-1:0]  in_a,
  input  logic [MAG_W-1:0]  in_b,
  input  logic [GAIN_W-1:0] gain,
  input  logic [FRAC_W-1:0] frac,
  output logic              s1_valid,
  output logic [MAG_W-1:0]  s1_a,
  output logic [MAG_W-1:0]  s1_noise,
  output logic [MAG_W-1:0]  s1_floor
);
  localparam int unsigned NP_W = MAG_W + GAIN_W;
  localparam int unsigned NS_W = NP_W - GAIN_FRAC;
  localparam int unsigned FP_W = MAG_W + FRAC_W;

  logic [NP_W-1:0]  noise_prod;
  logic [NS_W-1:0]  noise_shift;
  logic [MAG_W-1:0] noise_fit;
  logic [FP_W-1:0]  floor_prod;
  logic [MAG_W-1:0] floor_val;

  assign noise_prod  = {{GAIN_W{1'b0}}, in_b} * {{MAG_W{1'b0}}, gain};
  assign noise_shift = noise_prod[NP_W-1:GAIN_FRAC];

  generate
    if (NS_W > MAG_W) begin : g_sat
      logic over;
      assign over      = |noise_shift[NS_W-1:MAG_W];
      assign noise_fit = over ? {MAG_W{1'b1}} : noise_shift[MAG_W-1:0];
    end else begin : g_fit
      assign noise_fit = MAG_W'(noise_shift);
    end
  endgenerate

  assign floor_prod = {{FRAC_W{1'b0}}, in_a} * {{MAG_W{1'b0}}, frac};
  assign floor_val  = floor_prod[FP_W-1:FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_noise <= '0;
      s1_floor <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_a     <= in_a;
        s1_noise <= noise_fit;
        s1_floor <= floor_val;
      end
    end
  end
endmodule

// File: rtl/ssub_select_stage.sv
module ssub_select_stage #(
  parameter int unsigned MAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [MAG_W-1:0] s1_a,
  input  logic [MAG_W-1:0] s1_noise,
  input  logic [MAG_W-1:0] s1_floor,
  output logic             pick_diff,
  output logic             out_valid,
  output logic [MAG_W-1:0] out_mag
);
  logic signed [MAG_W:0] diff;
  logic signed [MAG_W:0] floor_s;
  logic [MAG_W-1:0]      chosen;

  assign diff      = $signed({1'b0, s1_a}) - $signed({1'b0, s1_noise});
  assign floor_s   = $signed({1'b0, s1_floor});
  assign pick_diff = diff > floor_s;
  assign chosen    = pick_diff ? diff[MAG_W-1:0] : s1_floor;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_mag <= chosen;
    end
  end
endmodule

// File: rtl/spectral_sub.sv
module spectral_sub #(
  parameter int unsigned MAG_W     = ssub_pkg::MAG_W_DEF,
  parameter int unsigned GAIN_W    = ssub_pkg::GAIN_W_DEF,
  parameter int unsigned GAIN_FRAC = ssub_pkg::GAIN_FRAC,
  parameter int unsigned FRAC_W    = ssub_pkg::FRAC_W_DEF,
  parameter int unsigned CFG_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             in_valid,
  input  logic [MAG_W-1:0] in_a,
  input  logic [MAG_W-1:0] in_b,
  output logic             out_valid,
  output logic [MAG_W-1:0] out_mag
);
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;

  logic [GAIN_W-1:0] gain_q;
  logic [FRAC_W-1:0] frac_q;
  logic              s1_valid;
  logic [MAG_W-1:0]  s1_a;
  logic [MAG_W-1:0]  s1_noise;
  logic [MAG_W-1:0]  s1_floor;
  logic              pick_diff;

  ssub_coef_regs #(
    .DATA_W(CFG_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W),
    .GAIN_RST(GAIN_ONE), .FRAC_RST('0)
  ) i_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_data), .gain_q(gain_q), .frac_q(frac_q)
  );

  ssub_scale_stage #(
    .MAG_W(MAG_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .FRAC_W(FRAC_W)
  ) i_scale (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .gain(gain_q), .frac(frac_q), .s1_valid(s1_valid), .s1_a(s1_a),
    .s1_noise(s1_noise), .s1_floor(s1_floor)
  );

  ssub_select_stage #(.MAG_W(MAG_W)) i_select (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_a(s1_a),
    .s1_noise(s1_noise), .s1_floor(s1_floor), .pick_diff(pick_diff),
    .out_valid(out_valid), .out_mag(out_mag)
  );
endmodule

// File: rtl/ssub_chk.sv
module ssub_chk #(
  parameter int unsigned MAG_W  = 16,
  parameter int unsigned GAIN_W = 16,
  parameter int unsigned FRAC_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              in_valid,
  input logic [MAG_W-1:0]  in_a,
  input logic              out_valid,
  input logic [MAG_W-1:0]  out_mag,
  input logic [GAIN_W-1:0] gain_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic              s1_valid,
  input logic              pick_diff
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R5
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R4
  never_above_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && out_valid) |-> (out_mag <= $past(in_a, 2)));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && !out_valid) |-> $stable(out_mag));

  // R6
  coef_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && !$past(cfg_we)) |-> ($stable(gain_q) && $stable(frac_q)));

  // R4
  pick_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && pick_diff) |=> (out_valid && out_mag != '0));
endmodule

bind spectral_sub ssub_chk #(.MAG_W(MAG_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_valid(in_valid), .in_a(in_a),
  .out_valid(out_valid), .out_mag(out_mag), .gain_q(gain_q), .frac_q(frac_q),
  .s1_valid(s1_valid), .pick_diff(pick_diff)
);

// File: tb/test_spectral_sub.sv
`timescale 1ns/1ps
module test_spectral_sub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        out_valid;
  logic [15:0] out_mag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spectral_sub i_spectral_sub (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_mag(out_mag)
  );

  // {A, B, expected} with gain 2.0 and floor fraction 0.25
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {16'd1000,  16'd100,   16'd800},    // difference wins
    {16'd1000,  16'd400,   16'd250},    // just under floor
    {16'd1000,  16'd600,   16'd250},    // negative difference
    {16'd65535, 16'd0,     16'd65535},  // full scale, no noise
    {16'd0,     16'd5,     16'd0},      // zero signal
    {16'd40000, 16'd40000, 16'd10000},  // scaled noise saturates
    {16'd800,   16'd300,   16'd200},    // difference equals floor
    {16'd12345, 16'd1000,  16'd10345},  // floor truncated 3086
    {16'd3,     16'd1,     16'd1},      // tiny values
    {16'd5000,  16'd2499,  16'd1250}    // difference 2 vs floor 1250
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_coef(input logic sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic one_sample(input logic [15:0] a, input logic [15:0] b, input logic [15:0] exp,
                            input string req);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid after one edge"}, {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check({req, " valid after two edges"}, {15'd0, out_valid}, 16'd1);
    check(req, out_mag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset outputs
    check("R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R1 out_mag in reset", out_mag, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);

    // R1 reset coefficients: gain 1.0, fraction 0
    one_sample(16'd100, 16'd30, 16'd70, "R1 default gain");
    one_sample(16'd20, 16'd30, 16'd0, "R1 default floor zero");

    // R2 fractional gain 1.5 truncates
    write_coef(1'b0, 16'h1800);
    one_sample(16'd10, 16'd3, 16'd6, "R2 gain 1.5 truncation");

    // streamed table, R2 R3 R4 R5
    write_coef(1'b0, 16'h2000);
    write_coef(1'b1, 16'h4000);
    for (int j = 0; j < NV + 2; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R5 stream valid", {15'd0, out_valid}, 16'd1);
        check("R4 stream value", out_mag, VEC[j-2][15:0]);
      end
      if (j < NV) begin
        in_valid = 1'b1; in_a = VEC[j][47:32]; in_b = VEC[j][31:16];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R7 hold on idle cycles
    repeat (3) @(negedge clk);
    check("R7 idle valid", {15'd0, out_valid}, 16'd0);
    check("R7 idle hold", out_mag, VEC[NV-1][15:0]);

    // R6 write on the same edge as a sample
    write_coef(1'b1, 16'h0000);
    write_coef(1'b0, 16'h1000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 16'h3000;
    in_valid = 1'b1; in_a = 16'd100; in_b = 16'd10;
    @(negedge clk);
    cfg_we = 1'b0;
    in_valid = 1'b1; in_a = 16'd100; in_b = 16'd10;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 same-edge sample uses old gain", out_mag, 16'd90);
    @(negedge clk);
    check("R6 later sample uses new gain", out_mag, 16'd70);

    // R6 floor write leaves gain alone, R3 floor with fraction 0.5
    write_coef(1'b1, 16'h8000);
    one_sample(16'd1001, 16'd100, 16'd701, "R6 gain kept after floor write");
    one_sample(16'd1001, 16'd300, 16'd500, "R3 floor half of A");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule